// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A request carries three things: the virtual address, the base of the first-level table, and a flag that allows 1 KB tiny pages. The walker then issues one or two 32-bit word reads on a request/acknowledge memory port. It decodes each descriptor it reads and returns one of three outcomes:

- a completed mapping, with its physical address, mapping kind, domain, permission field and cacheable/bufferable pair;
- a translation fault;
- a bus error.

Four mapping sizes are supported. A 1 MB section is resolved by the first-level entry alone. Pages of 64 KB, 4 KB and 1 KB are reached through a coarse or a fine second-level table. Each size uses its own index arithmetic and its own permission layout.

The block serves one walk at a time and only accepts a new request when it is idle. The result is held on the response port until the consumer takes it.

Top module: `xlat_walker`

## Requirements
- R1: The first memory read of a walk uses the address formed from table base bits [31:14], then virtual address bits [31:20], then two zero bits.
- R2: First-level code (bits [1:0]) 0 gives a translation fault after one read. Code 3 also gives a fault after one read when the tiny-page flag of the request is 0.
- R3: Whenever the first-level entry is not a fault and no bus error occurs, the domain output equals first-level bits [8:5]. This holds for page results and second-level faults as well.
- R4: First-level code 2 (section) completes after exactly one read with kind 1. The outputs are: physical address = {descriptor[31:20], va[19:0]}; cache pair = descriptor[3:2]; permission output = descriptor[11:10] in bits [1:0], with bits [7:2] zero.
- R5: First-level code 1 (coarse) makes a second read at {descriptor[31:10], va[19:12], 2'b00}. Code 3 (fine, tiny flag set) makes a second read at {descriptor[31:12], va[19:10], 2'b00}.
- R6: Second-level code 0 is a translation fault. Second-level code 1 is a large page with kind 2: physical address = {descriptor[31:16], va[15:0]}, permission = descriptor[11:4], cache pair = descriptor[3:2].
- R7: Second-level code 2 is a small page with kind 3: physical address = {descriptor[31:12], va[11:0]}, permission = descriptor[11:4], cache pair = descriptor[3:2].
- R8: Second-level code 3 is a tiny page with kind 4: physical address = {descriptor[31:10], va[9:0]}, permission = descriptor[5:4] zero-extended to 8 bits, cache pair = descriptor[3:2].
- R9: An error flagged with the acknowledge of either read ends the walk at once, with no further read. The response then reports a bus error and not a translation fault, with kind, address, domain, permission and cache pair all zero.
- R10: On a translation fault, the kind is 0 and the physical address, permission and cache pair are zero. The domain is zero for a first-level fault.
- R11: The request is accepted only while the walker is idle. Exactly one response is given per accepted request, and that response stays valid and unchanged until it is taken.
- R12: A memory request, once raised, stays high with an unchanged address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (bits [31:14] used) |
| req_tiny_en | input | 1 | Allow fine tables and tiny pages |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Word read address |
| mem_ack | input | 1 | Read done, data or error valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read failed |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_pa | output | 32 | Physical address |
| rsp_kind | output | 3 | 0 none, 1 section, 2 large, 3 small, 4 tiny |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 8 | Permission field |
| rsp_cb | output | 2 | Cacheable/bufferable pair |
| rsp_fault | output | 1 | Translation fault |
| rsp_buserr | output | 1 | Memory read error |

## Verification
Directed walks cover each descriptor code on both levels. They include a fine entry with the tiny flag cleared and again with it set, which shows whether the flag gates only the first-level code 3. Other directed walks place an error on the first read and on the second read, which shows whether a bus error is kept apart from a fault and whether the walk stops early. A tiny descriptor reached through a coarse table shows whether second-level decoding is independent of the table kind. Random walks use mixed descriptors, random memory latency and response stalls, and compare read addresses, read count and every response field against a bench model. This separates the index arithmetic of each granularity and catches results that change during a stall.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned DOM_W  = 4;
  localparam int unsigned AP_W   = 8;
  localparam int unsigned CB_W   = 2;

  typedef enum logic [2:0] {
    MAP_NONE    = 3'd0,
    MAP_SECTION = 3'd1,
    MAP_LARGE   = 3'd2,
    MAP_SMALL   = 3'd3,
    MAP_TINY    = 3'd4
  } map_kind_e;

  typedef enum logic [1:0] {
    TOP_FAULT,
    TOP_SECTION,
    TOP_COARSE,
    TOP_FINE
  } top_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_RSP
  } walk_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] pa;
    map_kind_e         kind;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
    logic [CB_W-1:0]   cb;
  } xlat_res_t;

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_pkg::*;
(
  input  logic [WORD_W-1:0] desc,
  input  logic [19:0]       va_low,
  input  logic              tiny_en,
  output top_kind_e         kind,
  output xlat_res_t         sect_res,
  output logic [WORD_W-1:0] next_addr
);

  logic unused_bits;
  assign unused_bits = ^{desc[9], desc[4]};

  always_comb begin
    unique case (desc[1:0])
      2'd1:    kind = TOP_COARSE;
      2'd2:    kind = TOP_SECTION;
      2'd3:    kind = tiny_en ? TOP_FINE : TOP_FAULT;
      default: kind = TOP_FAULT;
    endcase
  end

  always_comb begin
    sect_res.pa   = {desc[31:20], va_low};
    sect_res.kind = MAP_SECTION;
    sect_res.dom  = desc[8:5];
    sect_res.ap   = {6'b0, desc[11:10]};
    sect_res.cb   = desc[3:2];
  end

  // coarse tables index 256 words, fine tables index 1024 words
  always_comb begin
    if (desc[1:0] == 2'd1) next_addr = {desc[31:10], va_low[19:12], 2'b00};
    else                   next_addr = {desc[31:12], va_low[19:10], 2'b00};
  end

endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
  import xlat_pkg::*;
(
  input  logic [WORD_W-1:0] desc,
  input  logic [15:0]       va_low,
  input  logic [DOM_W-1:0]  dom,
  output logic              fault,
  output xlat_res_t         page_res
);

  always_comb begin
    fault         = 1'b0;
    page_res.dom  = dom;
    page_res.cb   = desc[3:2];
    page_res.ap   = desc[11:4];
    page_res.kind = MAP_NONE;
    page_res.pa   = '0;
    unique case (desc[1:0])
      2'd1: begin
        page_res.kind = MAP_LARGE;
        page_res.pa   = {desc[31:16], va_low};
      end
      2'd2: begin
        page_res.kind = MAP_SMALL;
        page_res.pa   = {desc[31:12], va_low[11:0]};
      end
      2'd3: begin
        page_res.kind = MAP_TINY;
        page_res.pa   = {desc[31:10], va_low[9:0]};
        page_res.ap   = {6'b0, desc[5:4]};
      end
      default: begin
        fault       = 1'b1;
        page_res.ap = '0;
        page_res.cb = '0;
      end
    endcase
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] req_base,
  input  logic        req_tiny_en,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_pa,
  output logic [2:0]  rsp_kind,
  output logic [3:0]  rsp_domain,
  output logic [7:0]  rsp_ap,
  output logic [1:0]  rsp_cb,
  output logic        rsp_fault,
  output logic        rsp_buserr
);

  walk_state_e       state_q, state_d;
  logic [31:0]       va_q, va_d;
  logic [17:0]       tbl_q, tbl_d;
  logic              tiny_q, tiny_d;
  logic [31:0]       rd2_addr_q, rd2_addr_d;
  logic [DOM_W-1:0]  dom_q, dom_d;
  xlat_res_t         res_q, res_d;
  logic              fault_q, fault_d;
  logic              bus_q, bus_d;

  top_kind_e         top_kind;
  xlat_res_t         sect_res;
  logic [31:0]       top_next;
  logic              page_fault;
  xlat_res_t         page_res;
  logic              unused_base;

  assign unused_base = ^req_base[13:0];

  xlat_l1_decode u_l1 (
    .desc      (mem_rdata),
    .va_low    (va_q[19:0]),
    .tiny_en   (tiny_q),
    .kind      (top_kind),
    .sect_res  (sect_res),
    .next_addr (top_next)
  );

  xlat_l2_decode u_l2 (
    .desc     (mem_rdata),
    .va_low   (va_q[15:0]),
    .dom      (dom_q),
    .fault    (page_fault),
    .page_res (page_res)
  );

  always_comb begin
    state_d    = state_q;
    va_d       = va_q;
    tbl_d      = tbl_q;
    tiny_d     = tiny_q;
    rd2_addr_d = rd2_addr_q;
    dom_d      = dom_q;
    res_d      = res_q;
    fault_d    = fault_q;
    bus_d      = bus_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d    = req_va;
          tbl_d   = req_base[31:14];
          tiny_d  = req_tiny_en;
          state_d = ST_RD1;
        end
      end
      ST_RD1: begin
        if (mem_ack) begin
          res_d   = '0;
          fault_d = 1'b0;
          bus_d   = 1'b0;
          state_d = ST_RSP;
          if (mem_err) begin
            bus_d = 1'b1;
          end else begin
            unique case (top_kind)
              TOP_FAULT:   fault_d = 1'b1;
              TOP_SECTION: res_d   = sect_res;
              default: begin
                rd2_addr_d = top_next;
                dom_d      = sect_res.dom;
                state_d    = ST_RD2;
              end
            endcase
          end
        end
      end
      ST_RD2: begin
        if (mem_ack) begin
          state_d = ST_RSP;
          fault_d = 1'b0;
          bus_d   = 1'b0;
          res_d   = '0;
          if (mem_err) begin
            bus_d = 1'b1;
          end else if (page_fault) begin
            fault_d   = 1'b1;
            res_d.dom = dom_q;
          end else begin
            res_d = page_res;
          end
        end
      end
      default: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      tbl_q      <= '0;
      tiny_q     <= 1'b0;
      rd2_addr_q <= '0;
      dom_q      <= '0;
      res_q      <= '0;
      fault_q    <= 1'b0;
      bus_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      va_q       <= va_d;
      tbl_q      <= tbl_d;
      tiny_q     <= tiny_d;
      rd2_addr_q <= rd2_addr_d;
      dom_q      <= dom_d;
      res_q      <= res_d;
      fault_q    <= fault_d;
      bus_q      <= bus_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_addr   = (state_q == ST_RD2) ? rd2_addr_q : {tbl_q, va_q[31:20], 2'b00};
  assign rsp_valid  = (state_q == ST_RSP);
  assign rsp_pa     = res_q.pa;
  assign rsp_kind   = res_q.kind;
  assign rsp_domain = res_q.dom;
  assign rsp_ap     = res_q.ap;
  assign rsp_cb     = res_q.cb;
  assign rsp_fault  = fault_q;
  assign rsp_buserr = bus_q;

  assert_read_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_idle_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || mem_req)));

  assert_rsp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_kind)
      && $stable(rsp_fault) && $stable(rsp_buserr));

  assert_fault_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_kind == 3'd0 && rsp_pa == 32'd0 && rsp_ap == 8'd0);

  assert_buserr_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_buserr |-> !rsp_fault && rsp_kind == 3'd0 && rsp_domain == 4'd0);

  assert_no_read_after_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !mem_req && rsp_valid);

  assert_tiny_ap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 3'd4 |-> rsp_ap[7:2] == 6'd0);

  assert_section_ap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 3'd1 |-> rsp_ap[7:2] == 6'd0);

endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_tiny_en;
  logic [31:0] req_va, req_base;
  logic        mem_req, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        rsp_valid, rsp_ready, rsp_fault, rsp_buserr;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_kind;
  logic [3:0]  rsp_domain;
  logic [7:0]  rsp_ap;
  logic [1:0]  rsp_cb;

  int checks = 0;
  int fails  = 0;

  // memory model state
  logic [31:0] m_d1, m_d2;
  bit          m_e1, m_e2;
  int          m_reads;
  logic [31:0] m_addr [2];
  int          m_dly;

  typedef struct {
    logic [31:0] a1, a2, pa;
    int          reads;
    logic [2:0]  kind;
    logic [3:0]  dom;
    logic [7:0]  ap;
    logic [1:0]  cb;
    bit          fault, bus;
  } exp_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_base(req_base), .req_tiny_en(req_tiny_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_kind(rsp_kind), .rsp_domain(rsp_domain), .rsp_ap(rsp_ap),
    .rsp_cb(rsp_cb), .rsp_fault(rsp_fault), .rsp_buserr(rsp_buserr)
  );

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (m_dly > 0) m_dly--;
      else begin
        if (m_reads < 2) m_addr[m_reads] = mem_addr;
        mem_rdata = (m_reads == 0) ? m_d1 : m_d2;
        mem_err   = (m_reads == 0) ? m_e1 : m_e2;
        mem_ack   = 1'b1;
        m_reads++;
        m_dly = $urandom % 3;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] va, base, d1, d2, input bit tiny, e1, e2);
    exp_t x;
    x.a1 = {base[31:14], va[31:20], 2'b00}; x.a2 = 0; x.reads = 1;
    x.pa = 0; x.kind = 0; x.dom = 0; x.ap = 0; x.cb = 0; x.fault = 0; x.bus = 0;
    if (e1) begin x.bus = 1; return x; end
    if (d1[1:0] == 2'd0 || (d1[1:0] == 2'd3 && !tiny)) begin x.fault = 1; return x; end
    x.dom = d1[8:5];
    if (d1[1:0] == 2'd2) begin
      x.kind = 1; x.pa = {d1[31:20], va[19:0]}; x.cb = d1[3:2]; x.ap = {6'b0, d1[11:10]};
      return x;
    end
    x.reads = 2;
    if (d1[1:0] == 2'd1) x.a2 = {d1[31:10], va[19:12], 2'b00};
    else                 x.a2 = {d1[31:12], va[19:10], 2'b00};
    if (e2) begin x.bus = 1; x.dom = 0; return x; end
    case (d2[1:0])
      2'd0: x.fault = 1;
      2'd1: begin x.kind = 2; x.pa = {d2[31:16], va[15:0]}; x.ap = d2[11:4]; x.cb = d2[3:2]; end
      2'd2: begin x.kind = 3; x.pa = {d2[31:12], va[11:0]}; x.ap = d2[11:4]; x.cb = d2[3:2]; end
      default: begin x.kind = 4; x.pa = {d2[31:10], va[9:0]}; x.ap = {6'b0, d2[5:4]}; x.cb = d2[3:2]; end
    endcase
    return x;
  endfunction

  task automatic walk(input logic [31:0] va, base, d1, d2, input bit tiny, e1, e2, input string tag);
    exp_t x;
    logic [31:0] pa0;
    logic [2:0]  k0;
    int n;
    x = model(va, base, d1, d2, tiny, e1, e2);
    m_d1 = d1; m_d2 = d2; m_e1 = e1; m_e2 = e2; m_reads = 0; m_dly = $urandom % 3;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R11 idle before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_va = va; req_base = base; req_tiny_en = tiny;
    @(negedge clk);
    req_valid = 1'b0; req_va = $urandom; req_base = $urandom; req_tiny_en = $urandom;
    n = 0;
    while (!rsp_valid && n < 60) begin
      chk(!req_ready, {tag, " R11 busy during walk"}, 64'(req_ready), 64'd0);
      @(negedge clk); n++;
    end
    pa0 = rsp_pa; k0 = rsp_kind;
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == pa0 && rsp_kind == k0, {tag, " R11 response held"},
          {rsp_pa, 29'(rsp_kind), 3'(rsp_valid)}, {pa0, 29'(k0), 3'd1});
    end
    chk(m_addr[0] == x.a1, {tag, " R1 first read address"}, 64'(m_addr[0]), 64'(x.a1));
    chk(m_reads == x.reads, {tag, " R4 R9 read count"}, 64'(m_reads), 64'(x.reads));
    if (x.reads == 2 && m_reads == 2)
      chk(m_addr[1] == x.a2, {tag, " R5 second read address"}, 64'(m_addr[1]), 64'(x.a2));
    chk(rsp_fault == x.fault && rsp_buserr == x.bus, {tag, " R2 R6 R9 fault/buserr"},
        {rsp_fault, rsp_buserr}, {x.fault, x.bus});
    chk(rsp_kind == x.kind, {tag, " R4 R6 R7 R8 R10 kind"}, 64'(rsp_kind), 64'(x.kind));
    chk(rsp_pa == x.pa, {tag, " R4 R6 R7 R8 R10 address"}, 64'(rsp_pa), 64'(x.pa));
    chk(rsp_domain == x.dom, {tag, " R3 domain"}, 64'(rsp_domain), 64'(x.dom));
    chk(rsp_ap == x.ap && rsp_cb == x.cb, {tag, " R4 R6 R7 R8 permission/cache"},
        {rsp_ap, rsp_cb}, {x.ap, x.cb});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready && !mem_req, {tag, " R11 single response"},
        {rsp_valid, req_ready, mem_req}, 64'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; req_valid = 0; req_va = 0; req_base = 0; req_tiny_en = 0;
    rsp_ready = 0; mem_ack = 0; mem_err = 0; mem_rdata = 0; m_reads = 0; m_dly = 0;
    m_addr[0] = 0; m_addr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R11 reset state",
        {req_ready, rsp_valid, mem_req}, 64'b100);

    walk(32'hABCD_1234, 32'h0004_C000, 32'hFED0_0DEE, 0, 0, 0, 0, "section");
    walk(32'h1234_5678, 32'h8000_0000, 32'h0000_0000, 0, 1, 0, 0, "R2 l1 fault");
    walk(32'h1234_5678, 32'h8000_0000, 32'h1234_5FF3, 0, 0, 0, 0, "R2 fine without tiny");
    walk(32'h0FF4_5678, 32'h0000_4000, 32'h1234_5C31, 32'hBEEF_0FF5, 1, 0, 0, "R6 coarse large");
    walk(32'h0FF4_5678, 32'h0000_4000, 32'h1234_5C31, 32'hBEEF_3A5A, 1, 0, 0, "R7 coarse small");
    walk(32'h0FF4_5EF8, 32'h0000_4000, 32'h1234_5FF3, 32'hCAFE_F43F, 1, 0, 0, "R8 fine tiny");
    walk(32'h0FF4_5EF8, 32'h0000_4000, 32'h1234_5FF1, 32'hCAFE_F43F, 0, 0, 0, "R8 coarse tiny");
    walk(32'h0FF4_5678, 32'h0000_4000, 32'h1234_51E1, 32'hFFFF_FFFC, 1, 0, 0, "R6 l2 fault");
    walk(32'h7777_7777, 32'hFFFF_C000, 32'hFFFF_FFF2, 0, 1, 1, 0, "R9 err on first");
    walk(32'h7777_7777, 32'hFFFF_C000, 32'hFFFF_FFF1, 32'h1, 1, 0, 1, "R9 err on second");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d1;
      d1 = $urandom;
      if (($urandom % 4) == 0) d1[1:0] = 2'd2;
      walk($urandom, $urandom, d1, $urandom, 1'($urandom), ($urandom % 16) == 0,
           ($urandom % 16) == 0, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule